// File: doc/BRIEF.md
# Serial Digital Video Scrambling Serializer

This block turns a stream of 10-bit parallel video words into one serial bitstream. It works in the serial clock domain: one clock runs at ten times the word rate, and a word strobe marks the cycle on which a new word is accepted. In video mode, each word first has its reserved code values clipped. Words that form a timing reference sequence (3FFh then 000h then 000h) are exempt from clipping. Each bit, least significant first, then passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1, and then through an optional NRZ-to-NRZI stage.

A raw mode turns the block into a plain parallel-to-serial converter for non-video data, with no clipping and no scrambling. 8-bit payloads travel in the upper eight bits of a word with the two low bits at zero. Spotting a timing reference needs two words of lookahead, so every word waits three strobes in a small delay line before it is serialized.

Top module: `sdi_serializer`

## Requirements
- R1: In video mode (raw_mode=0) each serial bit d becomes s = d XOR s[n-9] XOR s[n-4], where s[n-k] is the scrambled bit produced k cycles earlier.
- R2: With nrzi_en=1 the output toggles on every cycle whose scrambled bit is 1 and holds when it is 0.
- R3: With nrzi_en=0 the scrambled bit is driven to ser_out directly.
- R4: With raw_mode=1 no clipping and no scrambling occur, and the output bit equals the data bit before the NRZ/NRZI choice.
- R5: In video mode a word 000h to 003h is sent as 004h.
- R6: In video mode a word 3FCh to 3FFh is sent as 3FBh.
- R7: The three words of a 3FFh, 000h, 000h sequence are sent unchanged. Clipping resumes with the next word, and an isolated 3FFh is still clipped.
- R8: A word presented with the strobe is loaded for serialization on the third strobe after that. If it is loaded on edge k, its bit j appears on ser_out after edge k+1+j, so bits go out LSB first.
- R9: When no strobe arrives after the tenth bit, zero data bits are shifted in.
- R10: Synchronous active-high reset clears the delay line, shift register, scrambler history and NRZI state. ser_out reads 0 after a reset edge and stays 0 while no strobe arrives.
- R11: An 8-bit payload placed in bits 9:2 with bits 1:0 zero, such as 0A8h, passes unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | Word strobe, one cycle in every ten |
| word_in | input | 10 | Parallel input word |
| nrzi_en | input | 1 | 1 selects NRZI output, 0 selects NRZ |
| raw_mode | input | 1 | 1 bypasses clipping and scrambling |
| ser_out | output | 1 | Registered serial output |

## Verification
The bench decodes the serial stream with its own NRZI decoder and descrambler, and compares each recovered word with the expected clipped word. Wrong taps or a skipped scrambler show up as garbage words. The clipping cases sit on both edges of each reserved range. An isolated 3FFh must still be clipped, and the 000h that follows a complete timing reference must be clipped again; a design with a broken lookahead either clips the reference or protects too many words. The bench also checks that idle gaps decode to zero bits, and that a reset in the middle of a stream leaves a silent line. A design that keeps scrambler or NRZI state through reset would break that silence.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;
  localparam int SCR_LONG_TAP  = 9;
  localparam int SCR_SHORT_TAP = 4;
  localparam int TRS_LEN       = 3;

  typedef enum logic [1:0] {
    PASS_CLIP = 2'd0,
    PASS_RAW  = 2'd1,
    PASS_TRS  = 2'd2
  } pass_e;
endpackage

// File: rtl/sdi_word_pipe.sv
module sdi_word_pipe
  import sdi_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              raw_mode,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] load_word
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;
  localparam logic [WORD_W-1:0] FLOOR    = WORD_W'(4);
  localparam logic [WORD_W-1:0] CEIL     = ALL_ONES - WORD_W'(4);
  localparam int                CNT_W    = $clog2(TRS_LEN);

  logic [WORD_W-1:0] dly [TRS_LEN];
  logic [CNT_W-1:0]  prot_cnt;
  logic [WORD_W-1:0] oldest;
  logic [WORD_W-1:0] clipped;
  logic              trs_head;
  pass_e             pass_mode;

  assign oldest = dly[TRS_LEN-1];

  // Lookahead: oldest word is all ones and every younger word is zero
  always_comb begin
    trs_head = (oldest == ALL_ONES);
    for (int i = 0; i < TRS_LEN - 1; i++) begin
      if (dly[i] != '0) trs_head = 1'b0;
    end
  end

  always_comb begin
    if (raw_mode)                        pass_mode = PASS_RAW;
    else if (trs_head || prot_cnt != '0) pass_mode = PASS_TRS;
    else                                 pass_mode = PASS_CLIP;
  end

  always_comb begin
    if (oldest < FLOOR)     clipped = FLOOR;
    else if (oldest > CEIL) clipped = CEIL;
    else                    clipped = oldest;
  end

  assign load_word = (pass_mode == PASS_CLIP) ? clipped : oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TRS_LEN; i++) dly[i] <= '0;
      prot_cnt <= '0;
    end else if (stb) begin
      dly[0] <= word_in;
      for (int i = 1; i < TRS_LEN; i++) dly[i] <= dly[i-1];
      if (trs_head)            prot_cnt <= CNT_W'(TRS_LEN - 1);
      else if (prot_cnt != '0) prot_cnt <= prot_cnt - 1'b1;
    end
  end

  // R5: clipped words never fall below the floor
  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    (stb && pass_mode == PASS_CLIP) |-> (load_word >= FLOOR));

  // R6: clipped words never exceed the ceiling
  a_r6_ceiling: assert property (@(posedge clk) disable iff (rst)
    (stb && pass_mode == PASS_CLIP) |-> (load_word <= CEIL));

  // R7: protected reference words leave untouched
  a_r7_trs_pass: assert property (@(posedge clk) disable iff (rst)
    (stb && pass_mode == PASS_TRS) |-> (load_word == oldest));

  // R4: raw words leave untouched
  a_r4_raw_pass: assert property (@(posedge clk) disable iff (rst)
    (stb && raw_mode) |-> (load_word == oldest));
endmodule

// File: rtl/sdi_shifter.sv
module sdi_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [WORD_W-1:0] load_word,
  output logic              data_bit
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)      sreg <= '0;
    else if (stb) sreg <= load_word;
    else          sreg <= {1'b0, sreg[WORD_W-1:1]};
  end

  assign data_bit = sreg[0];

  // R9: idle shifting feeds zeros
  a_r9_zero_fill: assert property (@(posedge clk) disable iff (rst)
    !stb |=> (sreg[WORD_W-1] == 1'b0));

  // R8: the first bit out after a load is the word's LSB
  a_r8_lsb_first: assert property (@(posedge clk) disable iff (rst)
    stb |=> (data_bit == $past(load_word[0])));
endmodule

// File: rtl/sdi_scrambler.sv
module sdi_scrambler #(
  parameter int LONG_TAP  = 9,
  parameter int SHORT_TAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic data_bit,
  input  logic raw_mode,
  input  logic nrzi_en,
  output logic ser_out
);
  logic [LONG_TAP-1:0] hist;
  logic                scr_bit;
  logic                nrzi_q;

  assign scr_bit = raw_mode ? data_bit
                            : (data_bit ^ hist[LONG_TAP-1] ^ hist[SHORT_TAP-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      nrzi_q  <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      hist    <= {hist[LONG_TAP-2:0], scr_bit};
      nrzi_q  <= nrzi_q ^ scr_bit;
      ser_out <= nrzi_en ? (nrzi_q ^ scr_bit) : scr_bit;
    end
  end

  // R10: a reset edge leaves the line low
  a_r10_reset_low: assert property (@(posedge clk)
    rst |=> (ser_out == 1'b0));

  // R2: a scrambled one toggles the NRZI line
  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (nrzi_en && $past(nrzi_en) && scr_bit) |=> (ser_out != $past(ser_out)));

  // R3 and R4: raw data with NRZ output reaches the line unchanged
  a_r3_direct: assert property (@(posedge clk) disable iff (rst)
    (!nrzi_en && raw_mode) |=> (ser_out == $past(data_bit)));
endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer
  import sdi_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              nrzi_en,
  input  logic              raw_mode,
  output logic              ser_out
);
  logic [WORD_W-1:0] load_word;
  logic              data_bit;

  sdi_word_pipe #(.WORD_W(WORD_W)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .stb       (word_stb),
    .raw_mode  (raw_mode),
    .word_in   (word_in),
    .load_word (load_word)
  );

  sdi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .stb       (word_stb),
    .load_word (load_word),
    .data_bit  (data_bit)
  );

  sdi_scrambler #(.LONG_TAP(SCR_LONG_TAP), .SHORT_TAP(SCR_SHORT_TAP)) u_scr (
    .clk      (clk),
    .rst      (rst),
    .data_bit (data_bit),
    .raw_mode (raw_mode),
    .nrzi_en  (nrzi_en),
    .ser_out  (ser_out)
  );
endmodule

// File: tb/sdi_serializer_tb.sv
`timescale 1ns/1ps
module sdi_serializer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_stb = 1'b0;
  logic [9:0] word_in = '0;
  logic       nrzi_en = 1'b1;
  logic       raw_mode = 1'b0;
  logic       ser_out;

  always #2.5 clk = ~clk;

  sdi_serializer u_dut (
    .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
    .nrzi_en(nrzi_en), .raw_mode(raw_mode), .ser_out(ser_out)
  );

  // {input word, expected word after clipping}
  localparam logic [19:0] VID_VEC [16] = '{
    {10'h000, 10'h004}, {10'h001, 10'h004}, {10'h003, 10'h004}, {10'h004, 10'h004},
    {10'h155, 10'h155}, {10'h3FB, 10'h3FB}, {10'h3FC, 10'h3FB}, {10'h3FE, 10'h3FB},
    {10'h3FF, 10'h3FB}, {10'h200, 10'h200}, {10'h3FF, 10'h3FF}, {10'h000, 10'h000},
    {10'h000, 10'h000}, {10'h000, 10'h004}, {10'h0A8, 10'h0A8}, {10'h2AA, 10'h2AA}
  };
  localparam logic [9:0] RAW_VEC [10] = '{
    10'h000, 10'h3FF, 10'h3FC, 10'h003, 10'h0A8,
    10'h3FF, 10'h000, 10'h000, 10'h155, 10'h001
  };

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  logic       dec_bits [1024];
  int         stb_edge [64];
  int         ecount;
  int         n_stb;
  logic       prev_out;
  logic [8:0] dhist;
  logic [9:0] seg_in  [32];
  logic [9:0] seg_exp [32];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock with the given strobe/word; reference NRZI decode and descramble
  task automatic tick(input logic s, input logic [9:0] w);
    logic nz, d;
    word_stb = s;
    word_in  = w;
    @(posedge clk);
    if (s) begin stb_edge[n_stb] = ecount; n_stb++; end
    @(negedge clk);
    nz = nrzi_en ? (ser_out ^ prev_out) : ser_out;
    prev_out = ser_out;
    d = raw_mode ? nz : (nz ^ dhist[8] ^ dhist[3]);
    dhist = {dhist[7:0], nz};
    dec_bits[ecount] = d;
    ecount++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; word_stb = 1'b0;
    @(posedge clk); @(negedge clk);
    check(ser_out == 1'b0, "R10 reset", ser_out, 0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    prev_out = 1'b0; dhist = '0; ecount = 0; n_stb = 0;
  endtask

  // Serialize n words (+3 flush words for lookahead) and check the recovered words
  task automatic run_segment(input int n, input string tag);
    logic [9:0] got;
    int k;
    bit idle_ok;
    for (int i = 0; i < n + 3; i++) begin
      tick(1'b1, (i < n) ? seg_in[i] : 10'h200);
      for (int c = 0; c < 9; c++) tick(1'b0, 10'h000);
    end
    for (int c = 0; c < 8; c++) tick(1'b0, 10'h000);
    for (int i = 0; i < n; i++) begin
      k = stb_edge[i + 3];
      for (int j = 0; j < 10; j++) got[j] = dec_bits[k + 1 + j];
      check(got == seg_exp[i], tag, got, seg_exp[i]);
    end
    // R9: bits after the last word with no strobe decode to zero
    k = stb_edge[n + 2];
    idle_ok = 1;
    for (int j = 10; j < 16; j++) if (dec_bits[k + 1 + j] !== 1'b0) idle_ok = 0;
    check(idle_ok, "R9 idle zero fill", idle_ok, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit quiet;
    prev_out = 1'b0; dhist = '0; ecount = 0; n_stb = 0;

    // Segment A: video, NRZI on. R1 R2 R5 R6 R7 R8 R11
    nrzi_en = 1'b1; raw_mode = 1'b0;
    do_reset();
    foreach (VID_VEC[i]) begin
      seg_in[i]  = VID_VEC[i][19:10];
      seg_exp[i] = VID_VEC[i][9:0];
    end
    run_segment(16, "R1 R2 R5 R6 R7 R8 R11 video nrzi");

    // Segment B: video, NRZ. R3 R1
    nrzi_en = 1'b0; raw_mode = 1'b0;
    do_reset();
    run_segment(16, "R3 R1 R5 R6 R7 video nrz");

    // Segment C: raw, NRZI on. R4 R11
    nrzi_en = 1'b1; raw_mode = 1'b1;
    do_reset();
    foreach (RAW_VEC[i]) begin seg_in[i] = RAW_VEC[i]; seg_exp[i] = RAW_VEC[i]; end
    run_segment(10, "R4 R11 raw nrzi");

    // Segment D: raw, NRZ. R4 R3
    nrzi_en = 1'b0; raw_mode = 1'b1;
    do_reset();
    run_segment(10, "R4 R3 raw nrz");

    // R10: reset in mid-stream, then silence with no strobes
    nrzi_en = 1'b1; raw_mode = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(1'b1, 10'h2D3);
      for (int c = 0; c < 4; c++) tick(1'b0, 10'h000);
    end
    do_reset();
    quiet = 1;
    for (int c = 0; c < 30; c++) begin
      tick(1'b0, 10'h3FF);
      if (ser_out !== 1'b0) quiet = 0;
    end
    check(quiet, "R10 silent after reset", quiet, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule